// File: doc/BRIEF.md
# Ethernet Receive Frame Writer

This block takes one received Ethernet frame at a time as a byte stream and lays it out in a packet buffer slot. At the start of a frame it asks an external allocator for a slot. It copies the payload into that slot and fills any frame shorter than the minimum length with zero bytes. It then appends the frame check value, a two-byte trailer and a four-byte header holding the stored byte count. When the slot is complete it pulses a receive event that carries the slot number. A downstream queue or interrupt controller picks up that event.

Frames are dropped when reception is switched off, when soft reset is held, when the allocator has no free slot, or when the frame is too long for one slot. A dropped frame leaves no completed slot behind. If a slot was already granted for an oversized frame, that slot goes back to the allocator through a release pulse.

The byte input is a valid/ready stream. A byte moves on a clock edge where `in_valid` and `in_ready` are both high. `in_last` marks the final byte of a frame. The source must hold `in_data`, `in_last` and `in_valid` steady until the byte is taken. While the block waits for the allocator and while it writes padding, the check value, the trailer and the header, it holds `in_ready` low. The first byte of a frame stays on the input, not taken, until a slot is granted or the frame is found to be dropped. The allocator uses a request/acknowledge pair. The buffer write port has no back-pressure: it accepts one byte per cycle.

Top module: `rxf_frame_writer`

## Requirements
- R1: If `rx_en` is low or `soft_rst` is high when a frame's first byte is presented, the whole frame is drained with `in_ready` high. There is no allocator request, no buffer write and no receive event.
- R2: `alloc_req` stays high until a cycle in which `alloc_ack` is high, and no input byte is accepted while `alloc_req` is high.
- R3: If the acknowledged `alloc_code` equals the failure code 0x80, the frame is drained without any buffer write or receive event. Any other code selects slot `alloc_code[SLOT_W-1:0]`.
- R4: Every buffer write goes to address `{slot, offset}`. Payload byte i is written at offset 4+i. A frame shorter than 64 bytes is extended with zero bytes up to 64 bytes.
- R5: The frame check value is the reflected CRC-32 (polynomial 0xEDB88320, start value 0xFFFFFFFF, result inverted). It is computed over the padded payload, including a held odd last byte. Its four bytes are written least significant first, directly after the even part of the payload.
- R6: A frame of odd length (64 bytes or more) has its last byte written as the first trailer byte, followed by 0x60. Any other frame has trailer bytes 0x00 then 0x40. The trailer follows the check value.
- R7: Offsets 0 and 1 of the slot receive 0x00. Offsets 2 and 3 receive the stored byte count, least significant byte first. The stored byte count is the even payload length plus 10.
- R8: A frame longer than 2039 bytes (stored size above 2048) has its remaining bytes drained. The block pulses `alloc_rel` for one cycle, with `slot_out` naming the granted slot, and gives no receive event.
- R9: A completed frame gives a one-cycle `rx_event`, with `slot_out` naming the slot. This happens the cycle after the header's count high byte is written. There is exactly one event per completed frame.
- R10: `in_ready` is low during reset, while idle, while waiting for the allocator and while writing padding, check value, trailer and header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Block accepts the byte this cycle |
| rx_en | input | 1 | Receive enable |
| soft_rst | input | 1 | Soft reset; frames are dropped while high |
| alloc_req | output | 1 | Slot request to the allocator |
| alloc_ack | input | 1 | Allocator answer valid |
| alloc_code | input | 8 | Granted slot number or 0x80 for failure |
| alloc_rel | output | 1 | Returns the slot named on `slot_out` |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | SLOT_W+11 | Buffer write address {slot, offset} |
| buf_wdata | output | 8 | Buffer write byte |
| rx_event | output | 1 | Frame completed in slot `slot_out` |
| slot_out | output | SLOT_W | Slot for `rx_event` or `alloc_rel` |

## Verification
Each accepted payload byte shows up on the registered write port one cycle after its accepting edge. After the last byte, the block takes (64 − length) padding cycles for short frames, then four check value writes, two trailer writes and four header writes, one per cycle, and `rx_event` one cycle after the last header write. The bench records every write at the falling edge, when the registered outputs are steady, into a model of the buffer. It waits for the event under a cycle bound and then compares the whole slot image with an image built by its own functions. For dropped frames, the bench waits a fixed number of cycles and checks that the counts of writes, events and requests have not changed and, for oversized frames, that exactly one release pulse appeared.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_BODY, ST_PAD, ST_CRC, ST_TAIL, ST_HEAD, ST_DONE, ST_DROP
  } rxf_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_crc32.sv
module rxf_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] crc_q
);
  import rxf_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || init) crc_q <= 32'hFFFF_FFFF;
    else if (en)        crc_q <= crc32_step(crc_q, data);
  end
endmodule

// File: rtl/rxf_tail_fmt.sv
module rxf_tail_fmt (
  input  rxf_pkg::rxf_state_e st,
  input  logic [1:0]          k,
  input  logic [31:0]         crc_q,
  input  logic                odd,
  input  logic [7:0]          held,
  input  logic [15:0]         stored_cnt,
  output logic [7:0]          fmt_byte
);
  import rxf_pkg::*;

  logic [31:0] crc_fin;
  assign crc_fin = ~crc_q;

  always_comb begin
    fmt_byte = 8'h00;
    unique case (st)
      ST_CRC:  fmt_byte = crc_fin[8*k +: 8];
      ST_TAIL: fmt_byte = (k == 2'd0) ? (odd ? held : 8'h00) : (odd ? 8'h60 : 8'h40);
      ST_HEAD: begin
        case (k)
          2'd2:    fmt_byte = stored_cnt[7:0];
          2'd3:    fmt_byte = stored_cnt[15:8];
          default: fmt_byte = 8'h00;
        endcase
      end
      default: fmt_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int SLOT_W    = 2,
  parameter int BUF_BYTES = 2048,
  parameter int MIN_LEN   = 64,
  parameter logic [7:0] FAIL_CODE = 8'h80
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  input  logic                     in_last,
  output logic                     in_ready,
  input  logic                     rx_en,
  input  logic                     soft_rst,
  output logic                     alloc_req,
  input  logic                     alloc_ack,
  input  logic [7:0]               alloc_code,
  input  logic [7:0]               fmt_byte,
  output logic                     crc_init,
  output logic                     crc_en,
  output logic [7:0]               crc_byte,
  output rxf_pkg::rxf_state_e      st_o,
  output logic [1:0]               k_o,
  output logic                     odd_o,
  output logic [7:0]               held_o,
  output logic [15:0]              stored_cnt_o,
  output logic                     wr_en_d,
  output logic [$clog2(BUF_BYTES)-1:0] wr_ofs_d,
  output logic [7:0]               wr_data_d,
  output logic                     evt_d,
  output logic                     rel_d,
  output logic [SLOT_W-1:0]        slot_o
);
  import rxf_pkg::*;

  localparam int OFS_W     = $clog2(BUF_BYTES);
  localparam int HDR_BYTES = 4;
  localparam int CRC_BYTES = 4;
  localparam int TRL_BYTES = 2;
  localparam int OVERHEAD  = HDR_BYTES + CRC_BYTES + TRL_BYTES;
  localparam int MAX_LEN   = BUF_BYTES - OVERHEAD + 1;

  rxf_state_e        st_q, st_n;
  logic [OFS_W-1:0]  cnt_q, cnt_n, even_len, cnt_inc;
  logic [1:0]        k_q, k_n;
  logic              odd_q, odd_n;
  logic [7:0]        held_q, held_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              hold_last;

  assign even_len     = {cnt_q[OFS_W-1:1], 1'b0};
  assign cnt_inc      = cnt_q + 1'b1;
  assign hold_last    = in_last && !cnt_q[0] && (cnt_q >= OFS_W'(MIN_LEN));
  assign stored_cnt_o = 16'(even_len) + 16'(OVERHEAD);
  assign st_o   = st_q;
  assign k_o    = k_q;
  assign odd_o  = odd_q;
  assign held_o = held_q;
  assign slot_o = slot_q;

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    k_n       = k_q;
    odd_n     = odd_q;
    held_n    = held_q;
    slot_n    = slot_q;
    in_ready  = 1'b0;
    alloc_req = 1'b0;
    crc_init  = 1'b0;
    crc_en    = 1'b0;
    crc_byte  = in_data;
    wr_en_d   = 1'b0;
    wr_ofs_d  = '0;
    wr_data_d = fmt_byte;
    evt_d     = 1'b0;
    rel_d     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        crc_init = 1'b1;
        odd_n    = 1'b0;
        cnt_n    = '0;
        if (in_valid) st_n = (!rx_en || soft_rst) ? ST_DROP : ST_REQ;
      end
      ST_REQ: begin
        alloc_req = 1'b1;
        if (alloc_ack) begin
          if (alloc_code == FAIL_CODE) st_n = ST_DROP;
          else begin
            slot_n = alloc_code[SLOT_W-1:0];
            st_n   = ST_BODY;
          end
        end
      end
      ST_BODY: begin
        in_ready = 1'b1;
        if (in_valid) begin
          if (cnt_q == OFS_W'(MAX_LEN)) begin
            rel_d = 1'b1;
            st_n  = in_last ? ST_IDLE : ST_DROP;
          end else begin
            crc_en = 1'b1;
            cnt_n  = cnt_inc;
            if (hold_last) begin
              held_n = in_data;
              odd_n  = 1'b1;
            end else begin
              wr_en_d   = 1'b1;
              wr_ofs_d  = OFS_W'(HDR_BYTES) + cnt_q;
              wr_data_d = in_data;
            end
            if (in_last) begin
              k_n  = '0;
              st_n = (cnt_inc < OFS_W'(MIN_LEN)) ? ST_PAD : ST_CRC;
            end
          end
        end
      end
      ST_PAD: begin
        crc_en    = 1'b1;
        crc_byte  = 8'h00;
        wr_en_d   = 1'b1;
        wr_ofs_d  = OFS_W'(HDR_BYTES) + cnt_q;
        wr_data_d = 8'h00;
        cnt_n     = cnt_inc;
        if (cnt_inc == OFS_W'(MIN_LEN)) st_n = ST_CRC;
      end
      ST_CRC: begin
        wr_en_d  = 1'b1;
        wr_ofs_d = OFS_W'(HDR_BYTES) + even_len + OFS_W'(k_q);
        k_n      = k_q + 2'd1;
        if (k_q == 2'd3) st_n = ST_TAIL;
      end
      ST_TAIL: begin
        wr_en_d  = 1'b1;
        wr_ofs_d = OFS_W'(HDR_BYTES + CRC_BYTES) + even_len + OFS_W'(k_q);
        k_n      = (k_q == 2'd1) ? 2'd0 : k_q + 2'd1;
        if (k_q == 2'd1) st_n = ST_HEAD;
      end
      ST_HEAD: begin
        wr_en_d  = 1'b1;
        wr_ofs_d = OFS_W'(k_q);
        k_n      = k_q + 2'd1;
        if (k_q == 2'd3) st_n = ST_DONE;
      end
      ST_DONE: begin
        evt_d = 1'b1;
        st_n  = ST_IDLE;
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_last) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      k_q    <= '0;
      odd_q  <= 1'b0;
      held_q <= '0;
      slot_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      k_q    <= k_n;
      odd_q  <= odd_n;
      held_q <= held_n;
      slot_q <= slot_n;
    end
  end
endmodule

// File: rtl/rxf_frame_writer.sv
module rxf_frame_writer #(
  parameter int SLOT_W    = 2,
  parameter int BUF_BYTES = 2048,
  parameter int MIN_LEN   = 64,
  parameter logic [7:0] FAIL_CODE = 8'h80,
  localparam int OFS_W    = $clog2(BUF_BYTES),
  localparam int ADDR_W   = SLOT_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              rx_en,
  input  logic              soft_rst,
  output logic              alloc_req,
  input  logic              alloc_ack,
  input  logic [7:0]        alloc_code,
  output logic              alloc_rel,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              rx_event,
  output logic [SLOT_W-1:0] slot_out
);
  import rxf_pkg::*;

  logic              crc_init, crc_en;
  logic [7:0]        crc_byte, fmt_byte, held, wr_data_d;
  logic [31:0]       crc_q;
  rxf_state_e        st;
  logic [1:0]        k;
  logic              odd, wr_en_d, evt_d, rel_d;
  logic [15:0]       stored_cnt;
  logic [OFS_W-1:0]  wr_ofs_d;
  logic [SLOT_W-1:0] slot;

  rxf_ctrl #(
    .SLOT_W(SLOT_W), .BUF_BYTES(BUF_BYTES), .MIN_LEN(MIN_LEN), .FAIL_CODE(FAIL_CODE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .rx_en(rx_en), .soft_rst(soft_rst),
    .alloc_req(alloc_req), .alloc_ack(alloc_ack), .alloc_code(alloc_code),
    .fmt_byte(fmt_byte),
    .crc_init(crc_init), .crc_en(crc_en), .crc_byte(crc_byte),
    .st_o(st), .k_o(k), .odd_o(odd), .held_o(held), .stored_cnt_o(stored_cnt),
    .wr_en_d(wr_en_d), .wr_ofs_d(wr_ofs_d), .wr_data_d(wr_data_d),
    .evt_d(evt_d), .rel_d(rel_d), .slot_o(slot)
  );

  rxf_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en), .data(crc_byte), .crc_q(crc_q)
  );

  rxf_tail_fmt u_fmt (
    .st(st), .k(k), .crc_q(crc_q), .odd(odd), .held(held),
    .stored_cnt(stored_cnt), .fmt_byte(fmt_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      rx_event  <= 1'b0;
      alloc_rel <= 1'b0;
      slot_out  <= '0;
    end else begin
      buf_we    <= wr_en_d;
      buf_addr  <= {slot, wr_ofs_d};
      buf_wdata <= wr_data_d;
      rx_event  <= evt_d;
      alloc_rel <= rel_d;
      if (evt_d || rel_d) slot_out <= slot;
    end
  end
endmodule

// File: rtl/rxf_frame_writer_chk.sv
module rxf_frame_writer_chk #(
  parameter int OFS_W  = 11,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              alloc_req,
  input logic              alloc_ack,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              rx_event,
  input logic              alloc_rel
);
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !alloc_ack |=> alloc_req);

  a_r2_no_accept_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |-> !in_ready);

  a_r9_event_after_header: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |-> $past(buf_we) && ($past(buf_addr[OFS_W-1:0]) == OFS_W'(3)));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_event |=> !rx_event);

  a_r8_release_not_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_rel && rx_event));

  a_r8_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_rel |=> !alloc_rel);
endmodule

bind rxf_frame_writer rxf_frame_writer_chk #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .alloc_req(alloc_req),
  .alloc_ack(alloc_ack), .buf_we(buf_we), .buf_addr(buf_addr),
  .rx_event(rx_event), .alloc_rel(alloc_rel)
);

// File: tb/rxf_frame_writer_tb_top.sv
module rxf_frame_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_W     = 2;
  localparam int NSLOT      = 1 << SLOT_W;
  localparam int BUF_BYTES  = 2048;
  localparam int ADDR_W     = SLOT_W + 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_last = 0, rx_en = 1, soft_rst = 0;
  logic [7:0] in_data = 0;
  logic in_ready, alloc_req, alloc_rel, buf_we, rx_event;
  logic alloc_ack = 0;
  logic [7:0] alloc_code = 0;
  logic [ADDR_W-1:0] buf_addr;
  logic [7:0] buf_wdata;
  logic [SLOT_W-1:0] slot_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxf_frame_writer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .rx_en(rx_en), .soft_rst(soft_rst), .alloc_req(alloc_req),
    .alloc_ack(alloc_ack), .alloc_code(alloc_code), .alloc_rel(alloc_rel),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .rx_event(rx_event), .slot_out(slot_out)
  );

  logic [7:0] mem [0:NSLOT*BUF_BYTES-1];
  logic [7:0] frame [0:BUF_BYTES-1];
  int n_wr = 0, n_evt = 0, n_rel = 0, n_req = 0, viol_req = 0;
  int evt_slot = 0, rel_slot = 0;
  int checks = 0, fails = 0;
  int next_slot = 0, ack_wait = 0, ack_delay = 0;
  bit fail_mode = 0, prev_req = 0, prev_ack = 0;
  int seed_dummy;

  // monitor and allocator model, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (buf_we) begin mem[buf_addr] = buf_wdata; n_wr++; end
      if (rx_event) begin n_evt++; evt_slot = slot_out; end
      if (alloc_rel) begin n_rel++; rel_slot = slot_out; end
      if (alloc_req && in_ready) viol_req++;
      if (prev_req && !prev_ack && !alloc_req) viol_req++;
      if (alloc_ack) alloc_ack = 0;
      else if (alloc_req) begin
        if (ack_wait < ack_delay) ack_wait++;
        else begin
          alloc_ack = 1; n_req++; ack_wait = 0; ack_delay = $urandom_range(3);
          if (fail_mode) alloc_code = 8'h80;
          else begin alloc_code = 8'(next_slot); next_slot = (next_slot + 1) % NSLOT; end
        end
      end
    end
    prev_req = alloc_req;
    prev_ack = alloc_ack;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'd0, frame[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic send(int len, int gap);
    for (int i = 0; i < len; i++) begin
      if ($urandom_range(99) < gap) begin @(negedge clk); in_valid = 0; in_last = 0; end
      @(negedge clk);
      in_valid = 1; in_data = frame[i]; in_last = (i == len - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk); in_valid = 0; in_last = 0;
  endtask

  task automatic fill(int len);
    for (int i = 0; i < BUF_BYTES; i++) frame[i] = (i < len) ? 8'($urandom) : 8'h00;
  endtask

  task automatic run_good(int len, int gap);
    int s, w0, e0, plen, even, base, mism, cnt;
    bit odd;
    logic [31:0] crc_act;
    fill(len);
    s = next_slot; base = s * BUF_BYTES;
    for (int i = 0; i < BUF_BYTES; i++) mem[base + i] = 8'hA5;
    w0 = n_wr; e0 = n_evt;
    send(len, gap);
    for (int t = 0; t < 300 && n_evt == e0; t++) @(negedge clk);
    check(n_evt == e0 + 1, "R9", "event count", n_evt - e0, 1);
    check(evt_slot == s, "R9", "event slot", evt_slot, s);
    plen = (len < 64) ? 64 : len;
    odd  = (plen % 2) == 1;
    even = odd ? plen - 1 : plen;
    mism = 0;
    for (int i = 0; i < even; i++) if (mem[base + 4 + i] !== frame[i]) mism++;
    check(mism == 0, "R4", $sformatf("payload/pad mismatches len %0d", len), mism, 0);
    check(n_wr - w0 == even + 10, "R4", "write count", n_wr - w0, even + 10);
    crc_act = {mem[base+even+7], mem[base+even+6], mem[base+even+5], mem[base+even+4]};
    check(crc_act === ref_crc(plen), "R5", "check value", crc_act, ref_crc(plen));
    check(mem[base+even+8] === (odd ? frame[len-1] : 8'h00), "R6", "trailer byte 0",
          mem[base+even+8], odd ? frame[len-1] : 8'h00);
    check(mem[base+even+9] === (odd ? 8'h60 : 8'h40), "R6", "trailer control",
          mem[base+even+9], odd ? 8'h60 : 8'h40);
    cnt = {mem[base+3], mem[base+2]};
    check(cnt == even + 10 && mem[base] === 8'h00 && mem[base+1] === 8'h00, "R7", "header count",
          cnt, even + 10);
  endtask

  task automatic run_drop(int len, string req, bit expect_req, bit expect_rel);
    int w0, e0, q0, r0, s;
    fill(len);
    s = next_slot; w0 = n_wr; e0 = n_evt; q0 = n_req; r0 = n_rel;
    send(len, 10);
    repeat (20) @(negedge clk);
    check(n_evt == e0, req, "no event on drop", n_evt - e0, 0);
    check((n_req - q0) == int'(expect_req), req, "alloc requests", n_req - q0, int'(expect_req));
    check((n_rel - r0) == int'(expect_rel), req, "release pulses", n_rel - r0, int'(expect_rel));
    if (expect_rel) check(rel_slot == s, req, "released slot", rel_slot, s);
    else check(n_wr == w0, req, "no writes on drop", n_wr - w0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (4) @(negedge clk);
    check(!in_ready && !alloc_req && !buf_we && !rx_event, "R10", "outputs in reset",
          {in_ready, alloc_req, buf_we, rx_event}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!in_ready && !alloc_req, "R10", "idle ready/req", {in_ready, alloc_req}, 0);
    // directed corners
    run_good(1, 0);     // odd short: pad to 64
    run_good(63, 20);   // odd short
    run_good(64, 0);    // exact minimum
    run_good(65, 30);   // odd: byte into trailer
    run_good(100, 0);
    run_good(2039, 5);  // largest accepted
    run_drop(2040, "R8", 1, 1);
    run_good(66, 0);    // allocator still in step after release
    rx_en = 0; run_drop(70, "R1", 0, 0); rx_en = 1;
    soft_rst = 1; run_drop(30, "R1", 0, 0); soft_rst = 0;
    fail_mode = 1; run_drop(80, "R3", 1, 0); fail_mode = 0;
    // constrained random
    for (int n = 0; n < 14; n++) run_good($urandom_range(300, 1), $urandom_range(40));
    check(viol_req == 0, "R2", "request hold / accept during request", viol_req, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule